// File: doc/BRIEF.md
# Clock Speed Control with Idle Gating

This block keeps the clock-speed control word of a small processor core and turns the core's idle requests into clock-enable signals. The 16-bit control word holds an 8-bit multiplier field, a fixed bit that always reads as one, an idle-depth select and a 6-bit oscillator trim code. The six trim bits are not contiguous: five sit at the top of the word and one sits just below the idle-depth bit. Software writes the word through a plain write port. A separate load input copies a 6-bit trim source word into the split trim field.

When the core requests idle, the block drops the CPU clock enable. If the idle-depth bit is set, it also drops the enable of the secondary master/timer clock domain. Any wake line ends the idle. The core is then held stalled while a restart counter runs. The counter length depends on which reference oscillator is selected: the ceramic/crystal reference needs a longer restart than the RC reference. No enable that was dropped comes back until the stall has finished. The block produces enables, a stall flag and the trim code only. The oscillators and the clock multiplication are outside it.

Top module: `clkctl_top`

## Requirements
- R1: After reset, rd_data is 16'h0100, cpu_clk_en and mc_clk_en are 1, stall is 0 and trim_code is 0.
- R2: A cycle with wr_en high loads wr_data into the control word. From the next cycle rd_data shows that value, except that bit 8 always reads 1.
- R3: trim_code always equals {rd_data[15:11], rd_data[9]}. Bit 10 is the idle-depth select and bits 7..0 are the multiplier field.
- R4: A cycle with trim_ld high copies trim_src[5:1] into control bits 15..11 in the same order and trim_src[0] into bit 9. All other bits keep their values.
- R5: When wr_en and trim_ld are both high in the same cycle, the trim bits come from trim_src and every other bit comes from wr_data.
- R6: With bit 10 at 0, idle_req while running drops cpu_clk_en in the next cycle, and mc_clk_en stays 1.
- R7: With bit 10 at 1, idle_req while running drops both cpu_clk_en and mc_clk_en in the next cycle.
- R8: While idle, any nonzero wake bit raises stall in the next cycle. Stall then stays high for exactly RTO_DLY cycles if osc_sel was 0 at the wake, or exactly CRO_DLY cycles if osc_sel was 1.
- R9: Enables dropped by idle stay low for the whole stall. Both enables are 1 in the first cycle in which stall is 0 again.
- R10: The idle depth is taken from bit 10 when the idle starts. Writing bit 10 during idle or stall does not change mc_clk_en until the core runs again.
- R11: Wake bits while running have no effect. idle_req while idle or stalled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write data |
| trim_ld | input | 1 | Load the trim field from trim_src |
| trim_src | input | 6 | Trim source word |
| osc_sel | input | 1 | Selected reference: 1 ceramic/crystal, 0 RC |
| idle_req | input | 1 | Idle request from the core |
| wake | input | WAKE_W | Wake lines, any bit set ends idle |
| rd_data | output | 16 | Control word read-back |
| trim_code | output | 6 | Current trim code |
| cpu_clk_en | output | 1 | CPU clock enable |
| mc_clk_en | output | 1 | Secondary clock-domain enable |
| stall | output | 1 | Core held during oscillator restart |

## Verification
A wrong latched idle depth shows up on mc_clk_en in the first cycle of the idle. It also shows up whenever bit 10 is rewritten before the wake. A restart counter loaded with the wrong length, or decrementing wrongly, shifts the falling edge of stall away from the exact cycle count for the selected oscillator. That shift is visible when the stall ends. A broken trim mapping or a lost fixed bit appears on rd_data and trim_code one cycle after the load.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int CTL_W     = 16;
  localparam int TRIM_W    = 6;
  localparam int DEPTH_POS = 10;
  localparam int FIXED_POS = 8;
  localparam int TLOW_POS  = 9;
  localparam logic [CTL_W-1:0] CTL_RST = 16'h0100;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_STALL = 2'd2
  } pwr_state_e;

  // place a 6-bit trim word into the split field of a control word
  function automatic logic [CTL_W-1:0] place_trim(input logic [CTL_W-1:0] w,
                                                  input logic [TRIM_W-1:0] t);
    logic [CTL_W-1:0] r;
    r        = w;
    r[15:11] = t[5:1];
    r[9]     = t[0];
    return r;
  endfunction

  function automatic logic [TRIM_W-1:0] pick_trim(input logic [CTL_W-1:0] w);
    return {w[15:11], w[9]};
  endfunction
endpackage

// File: rtl/clkctl_rst_sync.sv
module clkctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              trim_ld,
  input  logic [TRIM_W-1:0] trim_src,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [TRIM_W-1:0] trim_code,
  output logic              deep_sel
);
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  assign ctl_en = wr_en | trim_ld;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en)   ctl_d = wr_data;
    if (trim_ld) ctl_d = place_trim(ctl_d, trim_src);
    ctl_d[FIXED_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign trim_code = pick_trim(ctl_q);
  assign deep_sel  = ctl_q[DEPTH_POS];

  // R2
  wr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q[7:0] == $past(wr_data[7:0]));
  // R4
  trim_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trim_ld |=> (ctl_q[15:11] == $past(trim_src[5:1])) && (ctl_q[9] == $past(trim_src[0])));
  // R4
  trim_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_ld && !wr_en) |=> (ctl_q[10] == $past(ctl_q[10])) && (ctl_q[7:0] == $past(ctl_q[7:0])));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(ctl_q));
endmodule

// File: rtl/clkctl_restart.sv
module clkctl_restart #(
  parameter int CRO_DLY = 1024,
  parameter int RTO_DLY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic osc_sel,
  output logic busy,
  output logic done
);
  localparam int MAX_DLY = (CRO_DLY > RTO_DLY) ? CRO_DLY : RTO_DLY;
  localparam int CW      = $clog2(MAX_DLY + 1);
  localparam logic [CW-1:0] CRO_LD = CW'(CRO_DLY - 1);
  localparam logic [CW-1:0] RTO_LD = CW'(RTO_DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          reg_en;

  assign done   = busy_q && (cnt_q == '0);
  assign busy   = busy_q;
  assign reg_en = start | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = osc_sel ? CRO_LD : RTO_LD;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (reg_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !start) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R8
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == ($past(osc_sel) ? CRO_LD : RTO_LD));
endmodule

// File: rtl/clkctl_idle_fsm.sv
module clkctl_idle_fsm
  import clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_req,
  input  logic wake_any,
  input  logic deep_sel,
  input  logic restart_done,
  output logic restart_start,
  output logic cpu_clk_en,
  output logic mc_clk_en,
  output logic stall
);
  pwr_state_e st_q, st_d;
  logic       deep_q;
  logic       deep_en;

  always_comb begin
    st_d          = st_q;
    restart_start = 1'b0;
    deep_en       = 1'b0;
    unique case (st_q)
      PS_RUN: if (idle_req) begin
        st_d    = PS_IDLE;
        deep_en = 1'b1;
      end
      PS_IDLE: if (wake_any) begin
        st_d          = PS_STALL;
        restart_start = 1'b1;
      end
      PS_STALL: if (restart_done) st_d = PS_RUN;
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       deep_q <= 1'b0;
    else if (deep_en) deep_q <= deep_sel;
  end

  assign cpu_clk_en = (st_q == PS_RUN);
  assign stall      = (st_q == PS_STALL);
  assign mc_clk_en  = !(deep_q && (st_q != PS_RUN));

  // R7
  mc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_clk_en |-> !cpu_clk_en);
  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> cpu_clk_en && mc_clk_en);
  // R8
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(wake_any));
  // R10
  depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !$past(cpu_clk_en)) |-> $stable(mc_clk_en));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
  parameter int CRO_DLY = 1024,
  parameter int RTO_DLY = 64,
  parameter int WAKE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              trim_ld,
  input  logic [5:0]        trim_src,
  input  logic              osc_sel,
  input  logic              idle_req,
  input  logic [WAKE_W-1:0] wake,
  output logic [15:0]       rd_data,
  output logic [5:0]        trim_code,
  output logic              cpu_clk_en,
  output logic              mc_clk_en,
  output logic              stall
);
  logic srst_n;
  logic deep_sel;
  logic wake_any;
  logic rs_start, rs_done, rs_busy;

  assign wake_any = |wake;

  clkctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  clkctl_reg u_reg (
    .clk(clk), .rst_n(srst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .trim_ld(trim_ld), .trim_src(trim_src),
    .ctl_q(rd_data), .trim_code(trim_code), .deep_sel(deep_sel)
  );

  clkctl_restart #(.CRO_DLY(CRO_DLY), .RTO_DLY(RTO_DLY)) u_rs (
    .clk(clk), .rst_n(srst_n),
    .start(rs_start), .osc_sel(osc_sel),
    .busy(rs_busy), .done(rs_done)
  );

  clkctl_idle_fsm u_fsm (
    .clk(clk), .rst_n(srst_n),
    .idle_req(idle_req), .wake_any(wake_any), .deep_sel(deep_sel),
    .restart_done(rs_done), .restart_start(rs_start),
    .cpu_clk_en(cpu_clk_en), .mc_clk_en(mc_clk_en), .stall(stall)
  );

  // R9
  stall_busy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    stall |-> rs_busy);
endmodule

// File: tb/sim_clkctl_top.sv
module sim_clkctl_top;
  localparam int CLK_PER = 10;
  localparam int CRO = 1024;
  localparam int RTO = 64;

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic        cpu;
    logic        mc;
    logic        stl;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, wr_en, trim_ld, osc_sel, idle_req;
  logic [15:0] wr_data;
  logic [5:0]  trim_src;
  logic [3:0]  wake;
  logic [15:0] rd_data;
  logic [5:0]  trim_code;
  logic cpu_clk_en, mc_clk_en, stall;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  exp_t q[$];
  logic [15:0] model;

  always #(CLK_PER/2) clk = ~clk;

  clkctl_top #(.CRO_DLY(CRO), .RTO_DLY(RTO), .WAKE_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trim_ld(trim_ld), .trim_src(trim_src), .osc_sel(osc_sel),
    .idle_req(idle_req), .wake(wake), .rd_data(rd_data),
    .trim_code(trim_code), .cpu_clk_en(cpu_clk_en),
    .mc_clk_en(mc_clk_en), .stall(stall)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      logic [5:0] et;
      e  = q.pop_front();
      et = {e.rd[15:11], e.rd[9]};
      n_cmp++;
      if (rd_data !== e.rd || trim_code !== et || cpu_clk_en !== e.cpu ||
          mc_clk_en !== e.mc || stall !== e.stl) begin
        n_bad++;
        $display("FAIL %s: got rd=%h trim=%h cpu=%b mc=%b stall=%b exp rd=%h trim=%h cpu=%b mc=%b stall=%b",
                 e.tag, rd_data, trim_code, cpu_clk_en, mc_clk_en, stall,
                 e.rd, et, e.cpu, e.mc, e.stl);
      end
    end
  end

  task automatic push(input string tag, input logic c, input logic m, input logic s);
    exp_t e;
    e.tag = tag; e.rd = model; e.cpu = c; e.mc = m; e.stl = s;
    q.push_back(e);
  endtask

  task automatic do_write(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = d | 16'h0100;
  endtask

  task automatic do_trim(input logic [5:0] t);
    trim_ld = 1'b1; trim_src = t;
    @(negedge clk);
    trim_ld = 1'b0;
    model[15:11] = t[5:1];
    model[9]     = t[0];
  endtask

  task automatic pulse_idle();
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  task automatic pulse_wake(input logic [3:0] w, input logic sel);
    wake = w; osc_sel = sel;
    @(negedge clk);
    wake = '0;
  endtask

  // wake already applied; stall is high now. Step through the rest.
  task automatic run_stall(input int len, input logic mc_low, input string tag);
    push({tag, " stall first"}, 1'b0, !mc_low, 1'b1);
    repeat (len - 1) @(negedge clk);
    push({tag, " stall last"}, 1'b0, !mc_low, 1'b1);
    @(negedge clk);
    push("R9 resume", 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; trim_ld = 0; osc_sel = 0; idle_req = 0;
    wr_data = '0; trim_src = '0; wake = '0;
    model = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push("R1 reset", 1'b1, 1'b1, 1'b0);

    // R2: fixed bit forced on writes
    do_write(16'h0000); push("R2 zero write", 1, 1, 0);
    do_write(16'h7A3C); push("R2 R3 write", 1, 1, 0);
    // R4: trim load into split field
    do_trim(6'b101101); push("R4 trim load", 1, 1, 0);
    do_trim(6'b010010); push("R4 trim load 2", 1, 1, 0);
    // R5: simultaneous write and trim load
    wr_en = 1; wr_data = 16'h0255; trim_ld = 1; trim_src = 6'b111111;
    @(negedge clk);
    wr_en = 0; trim_ld = 0;
    model = 16'h0255 | 16'h0100; model[15:11] = 5'b11111; model[9] = 1'b1;
    push("R5 write+trim", 1, 1, 0);

    // R11: wake while running ignored
    do_write(16'h0012);
    pulse_wake(4'b1111, 1'b0);
    push("R11 wake in run", 1, 1, 0);

    // R6: shallow idle, RC restart
    pulse_idle();
    push("R6 shallow idle", 0, 1, 0);
    repeat (3) @(negedge clk);
    pulse_idle();
    push("R11 idle in idle", 0, 1, 0);
    pulse_wake(4'b0100, 1'b0);
    run_stall(RTO, 1'b0, "R8 rc");

    // R7: deep idle, ceramic restart, R10 depth latched
    do_write(16'h0400);
    pulse_idle();
    push("R7 deep idle", 0, 0, 0);
    do_write(16'h0000);
    push("R10 depth write in idle", 0, 0, 0);
    pulse_wake(4'b0001, 1'b1);
    osc_sel = 1'b0;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    push("R11 idle in stall", 0, 0, 1);
    run_stall(CRO - 1, 1'b1, "R8 cro");

    // R10: depth set during shallow idle does not stop mc
    pulse_idle();
    push("R6 shallow again", 0, 1, 0);
    do_write(16'h0400);
    push("R10 depth set in idle", 0, 1, 0);
    pulse_wake(4'b1000, 1'b0);
    run_stall(RTO, 1'b0, "R8 rc2");

    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule